// File: doc/BRIEF.md
# Horizontal Sync Pulse Conditioner

This block sits between a composite-sync slicer and a line phase comparator, running on a 13.5 MHz clock. It passes the raw sync through a two-flop synchronizer. It times each pulse from its synchronized rising edge and from the low time that came before it. It measures where the edge falls relative to a one-cycle phase-reference strobe from the line timebase. Pulses that land outside an asymmetric acceptance window around the strobe are dropped. This removes half-line equalizing pulses. A sync that stays high too long closes the window early, which cuts the output and blocks further pulses in that line.

During the vertical interval, marked by a level input, pulses must prove their length before they count. A pulse that qualifies is widened so that its output always ends a fixed number of cycles after its rising edge. A pulse that follows the previous one after too short a low time bypasses all of this conditioning and is copied straight through.

The controlling state machine has six states. IDLE waits for a rising edge. PASS copies a bypassed pulse. LINE copies an accepted pulse outside the vertical interval. QUAL waits for a vertical-interval pulse to qualify. STRETCH holds the widened output. DROP waits out a rejected or finished pulse.

The transitions are as follows:
- IDLE goes to PASS on a rising edge with a short gap.
- IDLE goes to DROP on a rising edge outside the window.
- IDLE goes to QUAL on an accepted edge during the vertical interval.
- IDLE goes to LINE on an accepted edge otherwise.
- PASS, LINE, QUAL and DROP go back to IDLE when the input falls.
- QUAL goes to STRETCH on the 23rd high cycle.
- STRETCH goes to IDLE at its 62nd cycle if the input is low, and to DROP if it is still high.

Top module: `hsync_conditioner`

## Requirements
- R1: A synchronous active-high reset drives the output low from the first edge at which it is seen. After reset, no pulse is accepted until the first phase-reference strobe has arrived.
- R2: The position of a pulse is the number of cycles from the strobe cycle (position 0) to the cycle in which the synchronized input is first seen high. That cycle comes 2 cycles after the edge that samples the raw rise. A pulse is accepted when its position is 0 to 189 or 662 to 863, with a line of 864 cycles. Any other pulse is dropped for its whole length, inside or outside the vertical interval.
- R3: Outside the vertical interval, an accepted pulse is reproduced cycle for cycle, but only while the position is still inside the window. The output falls after position 189 even if the input stays high.
- R4: Outside the vertical interval, a sync that stays high for more than 65 cycles gives exactly 65 output cycles. Every later pulse is then dropped until the next strobe or until position 662 is reached.
- R5: During the vertical interval, an accepted pulse that stays high for 22 cycles or fewer produces no output. A longer pulse raises the output on its 23rd high cycle and keeps it high through its 62nd cycle, which gives 40 output cycles.
- R6: Once a vertical-interval pulse has qualified, the input has no effect until the widened output ends. The output width is the same for any qualifying input length, 23 cycles up to much longer than 62.
- R7: A pulse whose preceding synchronized low time is shorter than 22 cycles is copied unchanged, whatever its position and in either interval.
- R8: For an accepted pulse outside the vertical interval, the output rises 2 edges after the edge that samples the raw rise. For a qualifying vertical-interval pulse, it rises 24 edges after that edge.
- R9: Every strobe restarts the position count at 0, even when it arrives before a full line has elapsed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 13.5 MHz clock |
| rst | input | 1 | Synchronous active-high reset |
| csync_in | input | 1 | Raw sliced composite sync, asynchronous |
| phase_ref | input | 1 | One-cycle strobe at the expected line position |
| field_int | input | 1 | High during the vertical interval |
| hsync_out | output | 1 | Conditioned sync for the phase comparator |

## Verification
A wrong position count or window flag shows within one pulse. Either an equalizing-pulse position gives output, or a pulse at an edge of the window (positions 189/190 and 661/662) gives the wrong count. A stuck early-close flag shows on the next pulse of a following line, which then gives no output. A wrong age or state value changes the output width or the rise delay of the very pulse being processed. The bench therefore measures both quantities on every pulse. A wrong gap count shows as a bypassed pulse that appears outside the window, or as a close-following pulse that disappears.

// File: rtl/hsc_pkg.sv
package hsc_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PASS,
        ST_LINE,
        ST_QUAL,
        ST_STRETCH,
        ST_DROP
    } hsc_state_e;
endpackage

// File: rtl/hsc_sync.sv
module hsc_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) chain <= '0;
                else     chain <= d;
            end
        end else begin : g_multi
            always_ff @(posedge clk) begin
                if (rst) chain <= '0;
                else     chain <= {chain[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/hsc_gap_meter.sv
module hsc_gap_meter #(
    parameter int MIN_GAP = 22
) (
    input  logic clk,
    input  logic rst,
    input  logic level,
    output logic gap_ok
);
    localparam int GW = $clog2(MIN_GAP + 1);
    localparam logic [GW-1:0] C_MIN = GW'(MIN_GAP);

    logic [GW-1:0] low_cnt;

    // counts synchronized low cycles, saturating at the minimum gap
    always_ff @(posedge clk) begin
        if (rst || level)        low_cnt <= '0;
        else if (low_cnt != C_MIN) low_cnt <= low_cnt + 1'b1;
    end

    assign gap_ok = (low_cnt >= C_MIN);

    // R7: a high input always restarts the gap
    assert_gap_clear_R7: assert property (@(posedge clk) disable iff (rst)
        level |=> !gap_ok);
endmodule

// File: rtl/hsc_line_window.sv
module hsc_line_window #(
    parameter int LINE_LEN  = 864,
    parameter int WIN_EARLY = 202,
    parameter int WIN_LATE  = 189
) (
    input  logic clk,
    input  logic rst,
    input  logic phase_ref,
    input  logic long_now,
    output logic win_open
);
    localparam int PW = $clog2(LINE_LEN);
    localparam logic [PW-1:0] C_LAST  = PW'(LINE_LEN - 1);
    localparam logic [PW-1:0] C_START = PW'(LINE_LEN - WIN_EARLY);
    localparam logic [PW-1:0] C_LATE  = PW'(WIN_LATE);

    logic [PW-1:0] ph;
    logic          valid;
    logic          cut;
    logic [PW-1:0] pos;
    logic          raw_open;
    logic          win_start;

    assign pos       = phase_ref ? '0 : ph;
    assign raw_open  = (phase_ref || valid) && ((pos <= C_LATE) || (pos >= C_START));
    assign win_start = valid && !phase_ref && (pos == C_START);
    assign win_open  = raw_open && !cut && !long_now;

    always_ff @(posedge clk) begin
        if (rst) begin
            ph    <= '0;
            valid <= 1'b0;
        end else if (phase_ref) begin
            ph    <= PW'(1);
            valid <= 1'b1;
        end else if (valid) begin
            ph    <= (ph == C_LAST) ? '0 : ph + 1'b1;
        end
    end

    // early-close flag: set by a long sync, cleared at strobe or window start
    always_ff @(posedge clk) begin
        if (rst || phase_ref || win_start) cut <= 1'b0;
        else if (long_now)                 cut <= 1'b1;
    end

    // R1: nothing is accepted before the first strobe
    assert_closed_before_ref_R1: assert property (@(posedge clk) disable iff (rst)
        (!valid && !phase_ref) |-> !win_open);
endmodule

// File: rtl/hsc_pulse_fsm.sv
module hsc_pulse_fsm
    import hsc_pkg::*;
#(
    parameter int MIN_GAP     = 22,
    parameter int LONG_SYNC   = 65,
    parameter int STRETCH_LEN = 62
) (
    input  logic clk,
    input  logic rst,
    input  logic lvl,
    input  logic gap_ok,
    input  logic win_open,
    input  logic field_int,
    output logic long_now,
    output logic out_q
);
    localparam int AGE_MAX = ((LONG_SYNC > STRETCH_LEN) ? LONG_SYNC : STRETCH_LEN) + 1;
    localparam int AW = $clog2(AGE_MAX + 1);
    localparam logic [AW-1:0] C_MAX   = AW'(AGE_MAX);
    localparam logic [AW-1:0] C_QUAL  = AW'(MIN_GAP);
    localparam logic [AW-1:0] C_LONG  = AW'(LONG_SYNC);
    localparam logic [AW-1:0] C_STR   = AW'(STRETCH_LEN);
    localparam logic [AW-1:0] C_STR_L = AW'(STRETCH_LEN - 1);

    hsc_state_e    state, state_d;
    logic [AW-1:0] age, age_d, age_inc;
    logic          out_d;

    assign age_inc  = (age == C_MAX) ? age : age + 1'b1;
    assign long_now = (state == ST_LINE) && lvl && (age >= C_LONG);

    // next state and pulse age
    always_comb begin
        state_d = state;
        age_d   = age_inc;
        unique case (state)
            ST_IDLE: begin
                age_d = lvl ? AW'(1) : '0;
                if (lvl) begin
                    if (!gap_ok)        state_d = ST_PASS;
                    else if (!win_open) state_d = ST_DROP;
                    else if (field_int) state_d = ST_QUAL;
                    else                state_d = ST_LINE;
                end
            end
            ST_PASS, ST_LINE, ST_DROP: begin
                if (!lvl) state_d = ST_IDLE;
            end
            ST_QUAL: begin
                if (!lvl)                state_d = ST_IDLE;
                else if (age >= C_QUAL)  state_d = ST_STRETCH;
            end
            ST_STRETCH: begin
                if (age >= C_STR_L) state_d = lvl ? ST_DROP : ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // output decode
    always_comb begin
        unique case (state)
            ST_IDLE:    out_d = lvl && (!gap_ok || (win_open && !field_int));
            ST_PASS:    out_d = lvl;
            ST_LINE:    out_d = lvl && win_open;
            ST_QUAL:    out_d = lvl && (age >= C_QUAL);
            ST_STRETCH: out_d = (age < C_STR);
            ST_DROP:    out_d = 1'b0;
            default:    out_d = 1'b0;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            age   <= '0;
        end else begin
            state <= state_d;
            age   <= age_d;
        end
    end

    // output register
    always_ff @(posedge clk) begin
        if (rst) out_q <= 1'b0;
        else     out_q <= out_d;
    end

    // R2: a rejected pulse stays silent
    assert_drop_silent_R2: assert property (@(posedge clk) disable iff (rst)
        (state == ST_DROP && $past(state) == ST_DROP) |-> !out_q);

    // R5: nothing leaves while a vertical pulse is unproven
    assert_qual_silent_R5: assert property (@(posedge clk) disable iff (rst)
        (state == ST_QUAL) |-> !out_q);

    // R4: a long sync is cut after its limit
    assert_line_cap_R4: assert property (@(posedge clk) disable iff (rst)
        (state == ST_LINE && age > C_LONG) |-> !out_q);

    // R6: the widened pulse is held high throughout
    assert_stretch_high_R6: assert property (@(posedge clk) disable iff (rst)
        (state == ST_STRETCH) |-> out_q);
endmodule

// File: rtl/hsync_conditioner.sv
module hsync_conditioner #(
    parameter int LINE_LEN    = 864,
    parameter int WIN_EARLY   = 202,
    parameter int WIN_LATE    = 189,
    parameter int MIN_GAP     = 22,
    parameter int LONG_SYNC   = 65,
    parameter int STRETCH_LEN = 62,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic csync_in,
    input  logic phase_ref,
    input  logic field_int,
    output logic hsync_out
);
    logic lvl;
    logic gap_ok;
    logic win_open;
    logic long_now;

    hsc_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (csync_in),
        .q   (lvl)
    );

    hsc_gap_meter #(.MIN_GAP(MIN_GAP)) u_gap (
        .clk    (clk),
        .rst    (rst),
        .level  (lvl),
        .gap_ok (gap_ok)
    );

    hsc_line_window #(
        .LINE_LEN  (LINE_LEN),
        .WIN_EARLY (WIN_EARLY),
        .WIN_LATE  (WIN_LATE)
    ) u_win (
        .clk       (clk),
        .rst       (rst),
        .phase_ref (phase_ref),
        .long_now  (long_now),
        .win_open  (win_open)
    );

    hsc_pulse_fsm #(
        .MIN_GAP     (MIN_GAP),
        .LONG_SYNC   (LONG_SYNC),
        .STRETCH_LEN (STRETCH_LEN)
    ) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .lvl       (lvl),
        .gap_ok    (gap_ok),
        .win_open  (win_open),
        .field_int (field_int),
        .long_now  (long_now),
        .out_q     (hsync_out)
    );

    // R1: reset forces the output low on the next edge
    assert_reset_low_R1: assert property (@(posedge clk)
        rst |=> !hsync_out);
endmodule

// File: tb/sim_hsync_conditioner.sv
`timescale 1ns/1ps
module sim_hsync_conditioner;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic csync_in = 1'b0;
    logic phase_ref = 1'b0;
    logic field_int = 1'b0;
    logic hsync_out;

    int cyc = 0;
    int nchk = 0;
    int nfail = 0;
    int hi_cnt;
    int first_hi;
    int p_edge;
    int r_edge;

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    hsync_conditioner u0 (
        .clk       (clk),
        .rst       (rst),
        .csync_in  (csync_in),
        .phase_ref (phase_ref),
        .field_int (field_int),
        .hsync_out (hsync_out)
    );

    typedef struct packed {
        logic [9:0] off;
        logic [7:0] w;
        logic       vert;
        logic [7:0] ew;
        logic [7:0] ed;
        logic [3:0] req;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VECS [0:NV-1] = '{
        '{10'd1,   8'd50,  1'b0, 8'd50, 8'd2,  4'd3},  // R3 centred pulse
        '{10'd187, 8'd20,  1'b0, 8'd1,  8'd2,  4'd2},  // R2 last accepted position
        '{10'd188, 8'd20,  1'b0, 8'd0,  8'd0,  4'd2},  // R2 one past the late edge
        '{10'd660, 8'd30,  1'b0, 8'd30, 8'd2,  4'd2},  // R2 first accepted position
        '{10'd659, 8'd30,  1'b0, 8'd0,  8'd0,  4'd2},  // R2 one before the early edge
        '{10'd400, 8'd30,  1'b0, 8'd0,  8'd0,  4'd2},  // R2 equalizing pulse mid-line
        '{10'd150, 8'd60,  1'b0, 8'd38, 8'd2,  4'd3},  // R3 cut at window close
        '{10'd10,  8'd100, 1'b0, 8'd65, 8'd2,  4'd4},  // R4 long sync
        '{10'd10,  8'd65,  1'b0, 8'd65, 8'd2,  4'd4},  // R4 exactly at limit
        '{10'd5,   8'd30,  1'b1, 8'd40, 8'd24, 4'd5},  // R5 widened
        '{10'd5,   8'd22,  1'b1, 8'd0,  8'd0,  4'd5},  // R5 too short
        '{10'd5,   8'd23,  1'b1, 8'd40, 8'd24, 4'd5},  // R5 just qualifies
        '{10'd5,   8'd200, 1'b1, 8'd40, 8'd24, 4'd6},  // R6 long input, same width
        '{10'd400, 8'd30,  1'b1, 8'd0,  8'd0,  4'd2}   // R2 window in vertical interval
    };

    task automatic check(input string req, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
        if (hsync_out) begin
            hi_cnt++;
            if (first_hi < 0) first_hi = cyc;
        end
    endtask

    task automatic idle(input int n);
        csync_in = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    task automatic strobe();
        phase_ref = 1'b1;
        p_edge = cyc + 1;
        @(negedge clk);
        phase_ref = 1'b0;
    endtask

    task automatic wait_to(input int off);
        while (cyc + 1 < p_edge + off) @(negedge clk);
    endtask

    task automatic pulse(input int w, input int tail);
        hi_cnt = 0;
        first_hi = -1;
        csync_in = 1'b1;
        r_edge = cyc + 1;
        repeat (w) step();
        csync_in = 1'b0;
        repeat (tail) step();
    endtask

    initial begin
        repeat (4) @(negedge clk);
        check("R1 output low in reset", int'(hsync_out), 0);
        rst = 1'b0;
        idle(40);

        // table walk
        for (int i = 0; i < NV; i++) begin
            field_int = VECS[i].vert;
            idle(40);
            strobe();
            wait_to(int'(VECS[i].off));
            pulse(int'(VECS[i].w), 90);
            nchk++;
            if (hi_cnt != int'(VECS[i].ew)) begin
                nfail++;
                $display("FAIL R%0d vector %0d width actual=%0d expected=%0d",
                         VECS[i].req, i, hi_cnt, VECS[i].ew);
            end
            if (VECS[i].ew != 0) begin
                // R8 rise delay from the sampling edge of the raw rise
                check($sformatf("R8 vector %0d delay", i), first_hi - r_edge, int'(VECS[i].ed));
            end
        end
        field_int = 1'b0;

        // R4: early close blocks a later pulse until position 662
        idle(40);
        strobe();
        wait_to(10);
        pulse(100, 38);
        check("R4 long sync width", hi_cnt, 65);
        pulse(20, 40);
        check("R4 pulse after long sync blocked", hi_cnt, 0);
        wait_to(700);
        pulse(10, 40);
        check("R4 window reopened at start", hi_cnt, 10);

        // R7: short gaps bypass conditioning
        idle(40);
        strobe();
        wait_to(350);
        pulse(10, 10);
        check("R7 first pulse outside window", hi_cnt, 0);
        pulse(15, 40);
        check("R7 gap 10 bypass", hi_cnt, 15);
        pulse(10, 21);
        check("R7 conditioned pulse outside window", hi_cnt, 0);
        pulse(15, 22);
        check("R7 gap 21 bypass", hi_cnt, 15);
        pulse(15, 40);
        check("R7 gap 22 conditioned", hi_cnt, 0);
        field_int = 1'b1;
        pulse(10, 10);
        pulse(5, 30);
        check("R7 vertical bypass unchanged", hi_cnt, 5);
        field_int = 1'b0;

        // R9: a second strobe restarts the position
        idle(40);
        strobe();
        wait_to(300);
        strobe();
        wait_to(50);
        pulse(20, 40);
        check("R9 position restarted", hi_cnt, 20);

        // R1: reset during a widened pulse, then no acceptance before a strobe
        idle(40);
        field_int = 1'b1;
        strobe();
        wait_to(5);
        csync_in = 1'b1;
        repeat (35) @(negedge clk);
        check("R6 widened output high", int'(hsync_out), 1);
        rst = 1'b1;
        @(negedge clk);
        check("R1 output cleared by reset", int'(hsync_out), 0);
        repeat (3) @(negedge clk);
        check("R1 output held low", int'(hsync_out), 0);
        rst = 1'b0;
        field_int = 1'b0;
        idle(40);
        pulse(20, 40);
        check("R1 no acceptance before strobe", hi_cnt, 0);
        strobe();
        wait_to(3);
        pulse(20, 40);
        check("R1 accepted after first strobe", hi_cnt, 20);

        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        nchk++;
        nfail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end
endmodule